// File: doc/BRIEF.md
# Decimating Charge-Domain Filter

This block is a fixed-point, synthesizable model of the filter chain inside a direct-sampling mixer. It takes one signed sample on every clock and returns one filtered sample for every 32 inputs. Each input is first combined with a leaky history state. The history keeps a programmable fraction `alpha` of that combined value, and the remainder goes into the rotating slot that is currently active. There are eight slots, and each one is connected for eight consecutive samples, so each slot holds an 8-point moving sum and the rate drops by eight.

The eight slots form two banks of four, bank A (slots 0 to 3) and bank B (slots 4 to 7), and the two banks take turns. When the last slot of a bank has taken its eighth sample, the four slots of that bank are added together. This sum is a spatial average. It feeds a second first-order IIR stage, the output buffer, whose retention fraction is `beta`. The two moving sums act as anti-alias filters and the two leaky stages do the channel selection.

The sequencing uses a two-state machine. In state `BANK_A` the slots of bank A fill. On transition `A_DONE`, taken when the in-bank sample counter reaches 31, the machine moves to `BANK_B`. In `BANK_B` the slots of bank B fill. On transition `B_DONE` it returns to `BANK_A`. In every other cycle each state holds.

Top module: `charge_decim_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the history state, all eight slots and the output buffer clear to zero. After such an edge, `out_y` is 0 and `out_valid` is 0.
- R2: For each sample, let c = h + x. The new history is h' = sat_H(floor((alpha*c + 128)/256)), where sat_H clips to 18-bit signed. The active slot receives share = c - h'.
- R3: The slots are used in the order 0,1,...,7 and then wrap to 0. Each slot takes exactly 8 consecutive samples, starting with slot 0 after reset. Slots 0-3 are bank A and slots 4-7 are bank B.
- R4: The first of a slot's eight samples overwrites the slot with its share, which clears the value left from the previous rotation. The other seven samples add their share, saturating to 16-bit signed.
- R5: On the 32nd sample of a bank, the bank sum is the total of that bank's four slots, including the share of that sample.
- R6: At each bank sum S, the output buffer updates to y' = sat_O(floor((beta*y + (256-beta)*S + 128)/256)), where sat_O clips to 18-bit signed. The new value appears on `out_y` one clock after the sample that completes the bank.
- R7: `out_valid` is high for exactly one cycle per 32 samples. It first goes high one clock after the 32nd sample following reset.
- R8: The history saturates rather than wraps when a large input is held with `alpha` near 255. From then on the outputs follow the clipped arithmetic of R2.
- R9: A change of `alpha` or `beta` applies to the next sample or the next bank readout, with no delay.
- R10: Between readouts `out_y` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one input sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_x | input | IN_W (12) | Signed input sample |
| alpha | input | 8 | History retention fraction, value/256 |
| beta | input | 8 | Output buffer retention fraction, value/256 |
| out_y | output | OUT_W (18) | Signed decimated output |
| out_valid | output | 1 | One-cycle strobe when `out_y` updates |

## Verification
The bench first compares against hand-worked values. A slot that is not cleared on its second rotation would double the bank sum, and a rotation fault would mix the slot-index ramp across banks (176 expected after the second bank). Rounding is checked with alpha=128 on a constant input, where truncation instead of half-up rounding changes the 7936 total. An alternating input must cancel to zero inside each slot, and a coefficient switched just before a readout must act on that readout. Long runs with a full-scale input then drive the history into clipping, where a design that wraps would jump sign. A reset in the middle of a bank must restart the 32-sample strobe count.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int COEF_W     = 8;
    localparam int ROUND_BIAS = 1 << (COEF_W - 1);

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;
endpackage

// File: rtl/dcf_history.sv
module dcf_history
    import dcf_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int HIST_W = 18,
    parameter int SH_W   = HIST_W + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [IN_W-1:0]   in_x,
    input  logic [COEF_W-1:0]        alpha,
    output logic signed [SH_W-1:0]   share
);
    localparam int CW = HIST_W + 1;
    localparam int PW = CW + COEF_W + 2;
    localparam logic signed [PW-1:0] HMAX = (PW'(1) <<< (HIST_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] HMIN = -HMAX - PW'(1);

    logic signed [HIST_W-1:0] hist_q, hist_d;
    logic signed [CW-1:0]     comb_v;
    logic signed [PW-1:0]     prod, rnd;

    always_comb begin
        comb_v = CW'(hist_q) + CW'(in_x);
        prod   = PW'($signed({1'b0, alpha})) * PW'(comb_v) + PW'(ROUND_BIAS);
        rnd    = prod >>> COEF_W;
        if (rnd > HMAX)      hist_d = HIST_W'(HMAX);
        else if (rnd < HMIN) hist_d = HIST_W'(HMIN);
        else                 hist_d = HIST_W'(rnd);
        share  = SH_W'(comb_v) - SH_W'(hist_d);
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end
endmodule

// File: rtl/dcf_slot_bank.sv
module dcf_slot_bank #(
    parameter int SH_W     = 20,
    parameter int SLOT_W   = 16,
    parameter int PER_BANK = 4,
    parameter int BSUM_W   = SLOT_W + 2,
    parameter int IDX_W    = $clog2(2 * PER_BANK)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SH_W-1:0]  share,
    input  logic [IDX_W-1:0]        slot_idx,
    input  logic                    first_tap,
    output logic signed [BSUM_W-1:0] bank_sum
);
    localparam int NS = 2 * PER_BANK;
    localparam int AW = ((SH_W > SLOT_W) ? SH_W : SLOT_W) + 1;
    localparam logic signed [AW-1:0] SMAX = (AW'(1) <<< (SLOT_W - 1)) - AW'(1);
    localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

    logic signed [SLOT_W-1:0] slot_nx [NS];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic signed [SLOT_W-1:0] q, d;
        logic signed [AW-1:0]     base, tot;

        always_comb begin
            base = first_tap ? '0 : AW'(q);
            tot  = base + AW'(share);
            if (slot_idx != IDX_W'(g)) d = q;
            else if (tot > SMAX)       d = SLOT_W'(SMAX);
            else if (tot < SMIN)       d = SLOT_W'(SMIN);
            else                       d = SLOT_W'(tot);
        end

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end

        assign slot_nx[g] = d;
    end

    always_comb begin
        bank_sum = '0;
        for (int k = 0; k < PER_BANK; k++) begin
            bank_sum = bank_sum +
                BSUM_W'(slot_nx[(slot_idx[IDX_W-1] ? PER_BANK : 0) + k]);
        end
    end
endmodule

// File: rtl/dcf_out_iir.sv
module dcf_out_iir
    import dcf_pkg::*;
#(
    parameter int BSUM_W = 18,
    parameter int OUT_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [BSUM_W-1:0] bank_sum,
    input  logic [COEF_W-1:0]        beta,
    output logic signed [OUT_W-1:0]  y
);
    localparam int PW = ((BSUM_W > OUT_W) ? BSUM_W : OUT_W) + COEF_W + 4;
    localparam logic signed [PW-1:0] OMAX = (PW'(1) <<< (OUT_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] OMIN = -OMAX - PW'(1);

    logic [COEF_W:0]          wgt;
    logic signed [PW-1:0]     wide, rnd;
    logic signed [OUT_W-1:0]  y_d;

    always_comb begin
        wgt  = (COEF_W+1)'(1 << COEF_W) - {1'b0, beta};
        wide = PW'($signed({1'b0, beta})) * PW'(y)
             + PW'($signed({1'b0, wgt})) * PW'(bank_sum)
             + PW'(ROUND_BIAS);
        rnd  = wide >>> COEF_W;
        if (rnd > OMAX)      y_d = OUT_W'(OMAX);
        else if (rnd < OMIN) y_d = OUT_W'(OMIN);
        else                 y_d = OUT_W'(rnd);
    end

    always_ff @(posedge clk) begin
        if (rst)       y <= '0;
        else if (load) y <= y_d;
    end
endmodule

// File: rtl/charge_decim_filter.sv
module charge_decim_filter
    import dcf_pkg::*;
#(
    parameter int IN_W           = 12,
    parameter int HIST_GUARD     = 6,
    parameter int SLOT_GUARD     = 4,
    parameter int TAPS           = 8,
    parameter int SLOTS_PER_BANK = 4,
    localparam int OUT_W         = IN_W + SLOT_GUARD + $clog2(SLOTS_PER_BANK)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  in_x,
    input  logic [COEF_W-1:0]       alpha,
    input  logic [COEF_W-1:0]       beta,
    output logic signed [OUT_W-1:0] out_y,
    output logic                    out_valid
);
    localparam int HIST_W    = IN_W + HIST_GUARD;
    localparam int SH_W      = HIST_W + 2;
    localparam int SLOT_W    = IN_W + SLOT_GUARD;
    localparam int TAP_BITS  = $clog2(TAPS);
    localparam int SEL_BITS  = $clog2(SLOTS_PER_BANK);
    localparam int CNT_W     = TAP_BITS + SEL_BITS;
    localparam int IDX_W     = SEL_BITS + 1;
    localparam int BSUM_W    = SLOT_W + SEL_BITS;

    bank_e                    state_q, state_d;
    logic [CNT_W-1:0]         cnt_q;
    logic                     bank_done, first_tap, bank_b;
    logic [IDX_W-1:0]         slot_idx;
    logic signed [SH_W-1:0]   share;
    logic signed [BSUM_W-1:0] bank_sum;

    assign bank_done = &cnt_q;
    assign first_tap = (cnt_q[TAP_BITS-1:0] == '0);
    assign bank_b    = (state_q == BANK_B);
    assign slot_idx  = {bank_b, cnt_q[CNT_W-1:TAP_BITS]};

    // state register and in-bank sample counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BANK_A;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // transitions A_DONE and B_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_A: if (bank_done) state_d = BANK_B;
            BANK_B: if (bank_done) state_d = BANK_A;
        endcase
    end

    // output strobe
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= bank_done;
    end

    dcf_history #(
        .IN_W  (IN_W),
        .HIST_W(HIST_W),
        .SH_W  (SH_W)
    ) u_hist (
        .clk  (clk),
        .rst  (rst),
        .in_x (in_x),
        .alpha(alpha),
        .share(share)
    );

    dcf_slot_bank #(
        .SH_W    (SH_W),
        .SLOT_W  (SLOT_W),
        .PER_BANK(SLOTS_PER_BANK),
        .BSUM_W  (BSUM_W),
        .IDX_W   (IDX_W)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .share    (share),
        .slot_idx (slot_idx),
        .first_tap(first_tap),
        .bank_sum (bank_sum)
    );

    dcf_out_iir #(
        .BSUM_W(BSUM_W),
        .OUT_W (OUT_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (bank_done),
        .bank_sum(bank_sum),
        .beta    (beta),
        .y       (out_y)
    );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int OUT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_y,
    input logic             bank_b
);
    logic [4:0] ck_cnt;
    logic       ck_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_cnt  <= '0;
            ck_wrap <= 1'b0;
        end else begin
            ck_cnt <= ck_cnt + 1'b1;
            if (&ck_cnt) ck_wrap <= 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_y == '0 && !out_valid));

    a_r7_strobe_when_due: assert property (@(posedge clk) disable iff (rst)
        (ck_cnt == '0 && ck_wrap) |-> out_valid);

    a_r7_strobe_only_when_due: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ck_cnt == '0 && ck_wrap));

    a_r3_bank_alternates: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (bank_b != $past(bank_b)));

    a_r10_output_holds: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_y));
endmodule

bind charge_decim_filter dcf_checker #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .out_valid(out_valid),
    .out_y    (out_y),
    .bank_b   (bank_b)
);

// File: tb/tb_charge_decim_filter.sv
module tb_charge_decim_filter;
    localparam int IN_W  = 12;
    localparam int OUT_W = 18;
    localparam longint HMAX = 131071, HMIN = -131072;
    localparam longint SMAX = 32767,  SMIN = -32768;
    localparam longint OMAX = 131071, OMIN = -131072;

    localparam int NT = 8;
    localparam int T_ALPHA [NT] = '{0,   0,    0,    0,   128,  255,  200,  255};
    localparam int T_BETA  [NT] = '{0,   128,  0,    0,   0,    0,    64,   32};
    localparam int T_MODE  [NT] = '{0,   0,    1,    2,   0,    0,    3,    0};
    localparam int T_AMP   [NT] = '{100, 100,  1000, 1,   256,  2047, 0,    -2048};
    localparam int T_N     [NT] = '{32,  64,   64,   64,  32,   640,  640,  640};
    localparam int T_EXP   [NT] = '{3200,2400, 0,    176, 7936, -1,   -1,   -1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [IN_W-1:0]  in_x = '0;
    logic [7:0]              alpha = '0, beta = '0;
    logic signed [OUT_W-1:0] out_y;
    logic                    out_valid;

    int total = 0, bad = 0;
    bit done = 1'b0;
    string cur_tag = "R2";

    longint m_hist, m_y, exp_y;
    longint m_slot [8];
    int     m_cnt;
    bit     exp_valid;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    charge_decim_filter dut (
        .clk(clk), .rst(rst), .in_x(in_x), .alpha(alpha), .beta(beta),
        .out_y(out_y), .out_valid(out_valid)
    );

    function automatic longint clip(longint v, longint lo, longint hi);
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic model_reset();
        m_hist = 0; m_y = 0; m_cnt = 0; exp_valid = 0; exp_y = 0;
        for (int k = 0; k < 8; k++) m_slot[k] = 0;
    endtask

    task automatic model_step(longint x);
        longint c, h, sh, bs;
        int s;
        c = m_hist + x;
        h = clip((longint'(alpha) * c + 128) >>> 8, HMIN, HMAX);
        sh = c - h;
        m_hist = h;
        s = m_cnt / 8;
        m_slot[s] = clip(((m_cnt % 8) == 0) ? sh : m_slot[s] + sh, SMIN, SMAX);
        exp_valid = ((m_cnt % 32) == 31);
        if (exp_valid) begin
            bs = 0;
            for (int k = 0; k < 4; k++) bs += m_slot[(s / 4) * 4 + k];
            m_y = clip((longint'(beta) * m_y + longint'(256 - beta) * bs + 128) >>> 8,
                       OMIN, OMAX);
        end
        exp_y = m_y;
        m_cnt = (m_cnt + 1) % 64;
    endtask

    task automatic check_cycle();
        total++;
        if (out_valid !== exp_valid) begin
            bad++;
            $display("FAIL %s R7 valid got %0b exp %0b", cur_tag, out_valid, exp_valid);
        end
        total++;
        if (longint'(out_y) != exp_y) begin
            bad++;
            $display("FAIL %s %s y got %0d exp %0d", cur_tag,
                     exp_valid ? "R6" : "R10", out_y, exp_y);
        end
    endtask

    task automatic check_val(string tag, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_x = '0;
        repeat (2) @(negedge clk);
        model_reset();
        check_val("R1 reset y", longint'(out_y), 0);
        check_val("R1 reset valid", longint'(out_valid), 0);
        rst = 1'b0;
    endtask

    task automatic drive(int n, int mode, int amp);
        longint v;
        for (int i = 0; i < n; i++) begin
            unique case (mode)
                0: v = amp;
                1: v = (i % 2) ? -amp : amp;
                2: v = amp * (i / 8);
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    v = longint'($signed(lfsr[11:0]));
                end
            endcase
            in_x = IN_W'(v);
            model_step(v);
            @(negedge clk);
            check_cycle();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        for (int t = 0; t < NT; t++) begin
            case (t)
                1: cur_tag = "R6";
                3: cur_tag = "R3";
                4: cur_tag = "R2";
                5, 7: cur_tag = "R8";
                default: cur_tag = "R5";
            endcase
            do_reset();
            alpha = 8'(T_ALPHA[t]);
            beta  = 8'(T_BETA[t]);
            drive(T_N[t], T_MODE[t], T_AMP[t]);
            if (T_EXP[t] >= 0)
                check_val({cur_tag, " table final y"}, longint'(out_y), T_EXP[t]);
        end

        // R4: bank A revisited after a full rotation must start clean
        cur_tag = "R4";
        do_reset();
        alpha = 8'd0; beta = 8'd0;
        drive(96, 0, 100);
        check_val("R4 slot cleared on reuse", longint'(out_y), 3200);

        // R9: beta switched just before the next readout
        cur_tag = "R9";
        do_reset();
        alpha = 8'd0; beta = 8'd0;
        drive(32, 0, 50);
        check_val("R9 first bank", longint'(out_y), 1600);
        beta = 8'd255;
        drive(32, 0, 0);
        check_val("R9 beta applied", longint'(out_y), 1594);

        // R1/R7: reset in the middle of a bank restarts the strobe count
        cur_tag = "R7";
        alpha = 8'd90; beta = 8'd40;
        drive(20, 3, 0);
        do_reset();
        drive(70, 3, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule